// File: doc/BRIEF.md
# RAM Data-Line Test Sequencer

This block is a built-in self-test controller for a small synchronous RAM sitting on an 8-bit data bus. When started, it runs a fixed series of write/read checks. These checks are aimed at shorted, open or stuck data lines and at cells that cannot be set or cleared. The block drives the RAM port directly and compares every read word against the value it expects. It stops at the first disagreement and reports which phase failed, the address, the expected word and the word actually read.

The series has five steps. First, a single cleared bit walks across the bus at one fixed address. Next, a single set bit walks across the same address. Then every cell is cleared, set to all ones and checked. After that every cell is cleared again and checked. Finally, an optional burst of back-to-back alternating all-zero and all-one writes goes to the fixed address and ends on zero. Whether the run passes or fails, the RAM is left holding zero everywhere. After a failure the sequencer runs a dedicated clearing pass before it reports completion.

The RAM port is synchronous. A read issued in one cycle returns its data on the port in the next cycle, and the sequencer compares it in that cycle.

Top module: `dbus_selftest`

## Requirements
- R1: After reset, busy, done and fail are low and the RAM port is idle (mem_en low). The port stays idle whenever busy is low.
- R2: Phase code 1 (walking zero) writes, for j = 0 up to DW-1, the word with only bit j cleared to address FIX_ADDR. Each write is followed in the next cycle by a read of FIX_ADDR, and that read's data is compared in the cycle after the read is issued.
- R3: Phase code 2 (walking one) follows straight after phase 1. It does the same with the word that has only bit j set, for j = 0 up to DW-1.
- R4: Phase code 3 writes 00h to every address in ascending order, then FFh to every address in ascending order, then reads every address in ascending order expecting FFh.
- R5: Phase code 4 writes 00h to every address in ascending order, then reads every address in ascending order expecting 00h.
- R6: With BURST_EN set, phase code 5 makes 2*BURST_LEN+1 writes in consecutive cycles to FIX_ADDR, alternating 00h, FFh, …, 00h. It then reads FIX_ADDR expecting 00h.
- R7: The first miscompare sets fail and latches fail_phase (3-bit code above), fail_addr, fail_exp and fail_got. These hold unchanged until the next accepted start.
- R8: After a miscompare, no further reads are issued. 00h is written to every address in ascending order, and done rises 2^AW+1 clock edges after the edge that returned the bad word.
- R9: A run with no miscompare raises done 4*DW + 5*2^AW + 1 + (BURST_EN ? 2*BURST_LEN+2 : 0) edges after the edge that sampled start, with fail low. Every healthy RAM cell then holds 00h, on both the pass and the fail path.
- R10: start is ignored while busy. It is accepted when idle or done, begins a new run and clears fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a test run (idle or done only) |
| busy | output | 1 | Test run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | A miscompare was seen in this run |
| fail_phase | output | 3 | Phase code of the first miscompare |
| fail_addr | output | AW | Address of the first miscompare |
| fail_exp | output | DW | Expected word of the first miscompare |
| fail_got | output | DW | Word read at the first miscompare |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (read when low) |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid the cycle after a read |

## Verification
Every result is timed from the edge that samples start, with cycle index 0 meaning the state just after that edge. The bench counts falling edges from that point, so it knows the exact cycle index at every sample. It checks that done arrives at exactly the pass formula of R9. On the fail path, it checks that done arrives 2^AW+1 edges after the cycle whose read data disagreed. The bench logs the port in every cycle and checks the walking and burst patterns against the cycle each write or read is due in. The fault models in the bench RAM are placed so that the first miscompare lands at a known cycle in each phase.

// File: rtl/dbus_st_pkg.sv
package dbus_st_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_W0_WR,
    ST_W0_RD,
    ST_W1_WR,
    ST_W1_RD,
    ST_CLR3,
    ST_SET3,
    ST_RD3,
    ST_CLR4,
    ST_RD4,
    ST_BURST,
    ST_BRD,
    ST_DRAIN,
    ST_SCRUB,
    ST_DONE
  } st_t;

  typedef enum logic [2:0] {
    PK_ZERO,
    PK_ONES,
    PK_WALK0,
    PK_WALK1,
    PK_ALT
  } pk_t;

  localparam logic [2:0] PH_NONE  = 3'd0;
  localparam logic [2:0] PH_WALK0 = 3'd1;
  localparam logic [2:0] PH_WALK1 = 3'd2;
  localparam logic [2:0] PH_SET   = 3'd3;
  localparam logic [2:0] PH_CLEAR = 3'd4;
  localparam logic [2:0] PH_BURST = 3'd5;

endpackage

// File: rtl/dbus_st_cnt.sv
module dbus_st_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic [W-1:0] val,
  output logic         last
);

  logic [W-1:0] q;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)      q_nxt = '0;
    else if (inc) q_nxt = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (clr || inc) q <= q_nxt;
  end

  assign val  = q;
  assign last = (q == lim);

  // each sweep stops at its limit and never wraps past it
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !last);  // R4

endmodule

// File: rtl/dbus_st_pat.sv
module dbus_st_pat
  import dbus_st_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 8
) (
  input  pk_t           kind,
  input  logic [SW-1:0] step,
  output logic [DW-1:0] word
);

  logic [DW-1:0] onehot;

  always_comb begin
    for (int b = 0; b < DW; b++) onehot[b] = (step == SW'(b));
  end

  always_comb begin
    unique case (kind)
      PK_ZERO:  word = '0;
      PK_ONES:  word = '1;
      PK_WALK0: word = ~onehot;
      PK_WALK1: word = onehot;
      PK_ALT:   word = step[0] ? '1 : '0;
      default:  word = '0;
    endcase
  end

  AST_WALK_SINGLE: assert final ((kind != PK_WALK1) || ($countones(word) <= 1));  // R3

endmodule

// File: rtl/dbus_st_errcap.sv
module dbus_st_errcap #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          chk_vld,
  input  logic [2:0]    chk_ph,
  input  logic [AW-1:0] chk_addr,
  input  logic [DW-1:0] chk_exp,
  input  logic [DW-1:0] rdata,
  output logic          err_first,
  output logic          fail,
  output logic [2:0]    fail_phase,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_got
);

  logic cap_en;

  assign err_first = chk_vld && (rdata != chk_exp) && !fail;
  assign cap_en    = clr || err_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail       <= 1'b0;
      fail_phase <= '0;
      fail_addr  <= '0;
      fail_exp   <= '0;
      fail_got   <= '0;
    end else if (cap_en) begin
      fail       <= !clr;
      fail_phase <= clr ? 3'd0 : chk_ph;
      fail_addr  <= clr ? '0 : chk_addr;
      fail_exp   <= clr ? '0 : chk_exp;
      fail_got   <= clr ? '0 : rdata;
    end
  end

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> (fail && $stable(fail_addr) && $stable(fail_got) && $stable(fail_phase)));  // R7

endmodule

// File: rtl/dbus_selftest.sv
module dbus_selftest
  import dbus_st_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int FIX_ADDR  = 0,
  parameter bit BURST_EN  = 1'b1,
  parameter int BURST_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [2:0]    fail_phase,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_got,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int BW  = $clog2(2 * BURST_LEN + 2);
  localparam int SBW = $clog2(DW) + 1;
  localparam int CW0 = (AW > BW) ? AW : BW;
  localparam int CW  = (CW0 > SBW) ? CW0 : SBW;
  localparam logic [CW-1:0] LIM_WALK  = CW'(DW - 1);
  localparam logic [CW-1:0] LIM_ARRAY = CW'((1 << AW) - 1);
  localparam logic [CW-1:0] LIM_BURST = CW'(2 * BURST_LEN);
  localparam logic [AW-1:0] FIX       = AW'(FIX_ADDR);

  // reset: asserted asynchronously, released through two flops
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  st_t st_q, st_nxt;
  logic          cnt_clr, cnt_inc, cnt_last;
  logic [CW-1:0] cnt_val, cnt_lim;
  pk_t           kind;
  logic [DW-1:0] pat;
  logic [2:0]    ph_cur;
  logic          rd_issue, err_first, cap_clr;
  logic          chk_vld;
  logic [2:0]    chk_ph;
  logic [AW-1:0] chk_addr;
  logic [DW-1:0] chk_exp;

  dbus_st_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_q), .clr(cnt_clr), .inc(cnt_inc),
    .lim(cnt_lim), .val(cnt_val), .last(cnt_last)
  );

  dbus_st_pat #(.DW(DW), .SW(CW)) u_pat (
    .kind(kind), .step(cnt_val), .word(pat)
  );

  dbus_st_errcap #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_q), .clr(cap_clr),
    .chk_vld(chk_vld), .chk_ph(chk_ph), .chk_addr(chk_addr),
    .chk_exp(chk_exp), .rdata(mem_rdata), .err_first(err_first),
    .fail(fail), .fail_phase(fail_phase), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_got(fail_got)
  );

  // per-state decode: pattern kind, phase code, counter limit
  always_comb begin
    kind    = PK_ZERO;
    ph_cur  = PH_NONE;
    cnt_lim = LIM_ARRAY;
    unique case (st_q)
      ST_W0_WR, ST_W0_RD: begin kind = PK_WALK0; ph_cur = PH_WALK0; cnt_lim = LIM_WALK; end
      ST_W1_WR, ST_W1_RD: begin kind = PK_WALK1; ph_cur = PH_WALK1; cnt_lim = LIM_WALK; end
      ST_CLR3:            begin kind = PK_ZERO;  ph_cur = PH_SET;   end
      ST_SET3, ST_RD3:    begin kind = PK_ONES;  ph_cur = PH_SET;   end
      ST_CLR4, ST_RD4:    begin kind = PK_ZERO;  ph_cur = PH_CLEAR; end
      ST_BURST:           begin kind = PK_ALT;   ph_cur = PH_BURST; cnt_lim = LIM_BURST; end
      ST_BRD:             begin kind = PK_ZERO;  ph_cur = PH_BURST; end
      default:            begin kind = PK_ZERO;  ph_cur = PH_NONE;  end
    endcase
  end

  // RAM port drive
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cnt_val[AW-1:0];
    mem_wdata = pat;
    unique case (st_q)
      ST_W0_WR, ST_W1_WR, ST_BURST: begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = FIX; end
      ST_W0_RD, ST_W1_RD, ST_BRD:   begin mem_en = 1'b1; mem_addr = FIX; end
      ST_CLR3, ST_SET3, ST_CLR4, ST_SCRUB: begin mem_en = 1'b1; mem_we = 1'b1; end
      ST_RD3, ST_RD4:               begin mem_en = 1'b1; end
      default: ;
    endcase
  end

  assign rd_issue = mem_en && !mem_we;

  // next state
  always_comb begin
    st_nxt  = st_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    cap_clr = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start) begin
        st_nxt = ST_W0_WR; cnt_clr = 1'b1; cap_clr = 1'b1;
      end
      ST_W0_WR: st_nxt = ST_W0_RD;
      ST_W0_RD: if (cnt_last) begin st_nxt = ST_W1_WR; cnt_clr = 1'b1; end
                else begin st_nxt = ST_W0_WR; cnt_inc = 1'b1; end
      ST_W1_WR: st_nxt = ST_W1_RD;
      ST_W1_RD: if (cnt_last) begin st_nxt = ST_CLR3; cnt_clr = 1'b1; end
                else begin st_nxt = ST_W1_WR; cnt_inc = 1'b1; end
      ST_CLR3:  if (cnt_last) begin st_nxt = ST_SET3; cnt_clr = 1'b1; end else cnt_inc = 1'b1;
      ST_SET3:  if (cnt_last) begin st_nxt = ST_RD3;  cnt_clr = 1'b1; end else cnt_inc = 1'b1;
      ST_RD3:   if (cnt_last) begin st_nxt = ST_CLR4; cnt_clr = 1'b1; end else cnt_inc = 1'b1;
      ST_CLR4:  if (cnt_last) begin st_nxt = ST_RD4;  cnt_clr = 1'b1; end else cnt_inc = 1'b1;
      ST_RD4:   if (cnt_last) begin
                  st_nxt = BURST_EN ? ST_BURST : ST_DRAIN; cnt_clr = 1'b1;
                end else cnt_inc = 1'b1;
      ST_BURST: if (cnt_last) begin st_nxt = ST_BRD; cnt_clr = 1'b1; end else cnt_inc = 1'b1;
      ST_BRD:   st_nxt = ST_DRAIN;
      ST_DRAIN: st_nxt = ST_DONE;
      ST_SCRUB: if (cnt_last) st_nxt = ST_DONE; else cnt_inc = 1'b1;
      default:  st_nxt = ST_IDLE;
    endcase
    if (err_first) begin
      st_nxt  = ST_SCRUB;
      cnt_clr = 1'b1;
      cnt_inc = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) st_q <= ST_IDLE;
    else        st_q <= st_nxt;
  end

  // compare pipeline: read issued now, data arrives next cycle
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      chk_vld  <= 1'b0;
      chk_ph   <= '0;
      chk_addr <= '0;
      chk_exp  <= '0;
    end else begin
      chk_vld <= rd_issue;
      if (rd_issue) begin
        chk_ph   <= ph_cur;
        chk_addr <= mem_addr;
        chk_exp  <= pat;
      end
    end
  end

  assign busy = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done = (st_q == ST_DONE);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !busy |-> !mem_en);  // R1

  AST_WALK_READBACK: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_en && mem_we && (st_q == ST_W0_WR) && !err_first)
      |=> (mem_en && !mem_we && (mem_addr == $past(mem_addr))));  // R2

  AST_BURST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_BURST && mem_we && !err_first) |=>
      (st_q != ST_BURST || mem_wdata == ~$past(mem_wdata)));  // R6

  AST_NO_READ_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_q)
    fail |-> !rd_issue);  // R8

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(busy) |-> $past(start));  // R10

endmodule

// File: tb/tb_dbus_selftest.sv
module tb_dbus_selftest;

  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int BL    = 8;
  localparam int T_PASS = 4*DW + 5*DEPTH + 1 + 2*BL + 2;
  localparam int LOGN  = 4096;

  logic          clk = 1'b0;
  logic          rst_n, start;
  logic          busy, done, fail;
  logic [2:0]    fail_phase;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_exp, fail_got;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  dbus_selftest #(.AW(AW), .DW(DW), .FIX_ADDR(0), .BURST_EN(1'b1), .BURST_LEN(BL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .fail_phase(fail_phase), .fail_addr(fail_addr), .fail_exp(fail_exp),
    .fail_got(fail_got), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model with fault knobs
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ram_q;
  logic [DW-1:0] rd_and, rd_or, cell_and, cell_or;
  logic [AW-1:0] bad_addr;
  logic          slow_fall, prev_ff;

  assign mem_rdata = (ram_q & rd_and) | rd_or;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (!(slow_fall && mem_addr == bad_addr && mem_wdata == '0 && prev_ff))
          mem[mem_addr] <= (mem_addr == bad_addr) ? ((mem_wdata & cell_and) | cell_or) : mem_wdata;
      end else begin
        ram_q <= mem[mem_addr];
      end
    end
    prev_ff <= mem_en && mem_we && (mem_addr == bad_addr) && (mem_wdata == '1);
  end

  int nchk = 0;
  int nfail = 0;
  int cyc;
  logic          lg_en [LOGN];
  logic          lg_we [LOGN];
  logic [AW-1:0] lg_ad [LOGN];
  logic [DW-1:0] lg_wd [LOGN];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clean_faults();
    rd_and = '1; rd_or = '0; cell_and = '1; cell_or = '0;
    bad_addr = '0; slow_fall = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(8'hA5 ^ i[7:0]) | DW'(1);
  endtask

  function automatic int dirty_cells(input int skip);
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (i != skip && mem[i] != '0) n++;
    return n;
  endfunction

  // start a run; cyc counts edges from the one sampling start
  task automatic run(input bit poke_restart, output logic mid_busy);
    mid_busy = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; cyc = 0;
    while (!done && cyc < LOGN - 1) begin
      lg_en[cyc] = mem_en; lg_we[cyc] = mem_we; lg_ad[cyc] = mem_addr; lg_wd[cyc] = mem_wdata;
      if (cyc == 50) mid_busy = busy;
      start = poke_restart && (cyc == 100);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 fail after reset", fail, 0);
    chk("R1 mem_en after reset", mem_en, 0);
  endtask

  task automatic t_pass(input bit restart);
    logic mb;
    int bad;
    clean_faults();
    run(restart, mb);
    chk("R10 busy mid-run", mb, 1);
    chk("R9 pass done cycle", cyc, T_PASS);
    chk("R9 pass fail flag", fail, 0);
    chk("R9 pass memory cleared", dirty_cells(-1), 0);
    chk("R10 not busy at done", busy, 0);
    bad = 0;
    for (int j = 0; j < DW; j++) begin
      if (!(lg_en[2*j] && lg_we[2*j] && lg_ad[2*j] == 0 && lg_wd[2*j] == ~(DW'(1) << j))) bad++;
      if (!(lg_en[2*j+1] && !lg_we[2*j+1] && lg_ad[2*j+1] == 0)) bad++;
    end
    chk("R2 walking-zero port sequence", bad, 0);
    bad = 0;
    for (int j = 0; j < DW; j++) begin
      if (!(lg_en[2*DW+2*j] && lg_we[2*DW+2*j] && lg_ad[2*DW+2*j] == 0 && lg_wd[2*DW+2*j] == (DW'(1) << j))) bad++;
      if (!(lg_en[2*DW+2*j+1] && !lg_we[2*DW+2*j+1] && lg_ad[2*DW+2*j+1] == 0)) bad++;
    end
    chk("R3 walking-one port sequence", bad, 0);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      if (!(lg_we[4*DW+a] && lg_ad[4*DW+a] == AW'(a) && lg_wd[4*DW+a] == '0)) bad++;
      if (!(lg_we[4*DW+DEPTH+a] && lg_ad[4*DW+DEPTH+a] == AW'(a) && lg_wd[4*DW+DEPTH+a] == '1)) bad++;
      if (!(lg_en[4*DW+2*DEPTH+a] && !lg_we[4*DW+2*DEPTH+a] && lg_ad[4*DW+2*DEPTH+a] == AW'(a))) bad++;
    end
    chk("R4 clear/set/read sweep order", bad, 0);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      if (!(lg_we[4*DW+3*DEPTH+a] && lg_ad[4*DW+3*DEPTH+a] == AW'(a) && lg_wd[4*DW+3*DEPTH+a] == '0)) bad++;
      if (!(lg_en[4*DW+4*DEPTH+a] && !lg_we[4*DW+4*DEPTH+a] && lg_ad[4*DW+4*DEPTH+a] == AW'(a))) bad++;
    end
    chk("R5 clear/read sweep order", bad, 0);
    bad = 0;
    for (int k = 0; k <= 2*BL; k++) begin
      int c = 4*DW + 5*DEPTH + k;
      if (!(lg_en[c] && lg_we[c] && lg_ad[c] == 0 && lg_wd[c] == ((k % 2) ? '1 : '0))) bad++;
    end
    if (!(lg_en[4*DW+5*DEPTH+2*BL+1] && !lg_we[4*DW+5*DEPTH+2*BL+1])) bad++;
    chk("R6 burst alternation and readback", bad, 0);
  endtask

  task automatic t_fault(input string tag, input int cmp_cyc, input logic [2:0] ph,
                         input logic [AW-1:0] ad, input logic [DW-1:0] ex,
                         input logic [DW-1:0] got, input int skip);
    logic mb;
    run(1'b0, mb);
    chk({tag, " R7 fail flag"}, fail, 1);
    chk({tag, " R7 fail_phase"}, fail_phase, ph);
    chk({tag, " R7 fail_addr"}, fail_addr, ad);
    chk({tag, " R7 fail_exp"}, fail_exp, ex);
    chk({tag, " R7 fail_got"}, fail_got, got);
    chk({tag, " R8 done cycle"}, cyc, cmp_cyc + 1 + DEPTH);
    chk({tag, " R8 memory cleared"}, dirty_cells(skip), 0);
    repeat (3) @(negedge clk);
    chk({tag, " R7 fields held"}, {fail_phase, fail_addr, fail_got}, {ph, ad, got});
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    clean_faults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();

    // healthy RAM, with an extra start pulse while busy
    t_pass(1'b1);

    // read-path bit 3 stuck at 1: walking-zero step 3
    clean_faults(); rd_or = 8'h08;
    t_fault("R2 stuck1", 2*3 + 2, 3'd1, 8'h00, 8'hF7, 8'hFF, -1);

    // cell 5Ah bit 2 cannot be set
    clean_faults(); bad_addr = 8'h5A; cell_and = 8'hFB;
    t_fault("R4 cell", 4*DW + 2*DEPTH + 1 + 'h5A, 3'd3, 8'h5A, 8'hFF, 8'hFB, -1);

    // cell C3h bit 0 cannot be cleared
    clean_faults(); bad_addr = 8'hC3; cell_or = 8'h01;
    t_fault("R5 cell", 4*DW + 4*DEPTH + 1 + 'hC3, 3'd4, 8'hC3, 8'h00, 8'h01, 'hC3);

    // fixed cell drops a zero written right after a ones write
    clean_faults(); bad_addr = 8'h00; slow_fall = 1'b1;
    t_fault("R6 slowfall", 4*DW + 5*DEPTH + 2*BL + 2, 3'd5, 8'h00, 8'h00, 8'hFF, -1);

    // restart from done clears fail
    t_pass(1'b0);
    chk("R10 restart clears fail", fail, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule